// File: doc/BRIEF.md
# Block-Aligned Staging Scratchpad with Transfer Status

This block is a small staging buffer that sits in front of a protected memory. A host first sets a 16-bit target address, one byte at a time. It then opens a write, streams data bytes into the buffer and closes the write. Because transfers are block-aligned, the low address bits are forced to zero whatever the host writes, and data always fills the buffer from offset zero.

Before it asks for a commit, the host can read back the target address, the buffer contents and a read-only status byte to confirm that the transfer arrived intact. The status byte always shows an ending offset of all ones and carries fixed one bits. It also carries two flags. The partial flag marks a write that ended short of a full block. The accepted flag marks a block that has been handed on.

A commit request hands the whole block and its address to the memory controller as a one-cycle strobe. The block refuses the request while a write is still open or while the partial flag is set. Commands arrive on a byte-wide port with a 3-bit opcode. Reads go through a combinational select port.

Top module: `spad_stage`

## Requirements
- R1: After reset the target address reads 0x0000, the status byte reads 0x7F (partial flag 1, accepted flag 0) and `commit_o` is low.
- R2: Opcode 0 (address low) stores `cmd_data` with bits 2..0 forced to 0. Read select 8 returns this byte.
- R3: Opcode 1 (address high) stores `cmd_data` unchanged as address bits 15..8. Read select 9 returns this byte.
- R4: Inside an open write, each opcode 3 (data byte) stores its byte at the next offset, starting from 0. Read select k (0..7) returns offset k.
- R5: Data bytes beyond the eighth in a write, and data bytes sent while no write is open, change no buffer byte.
- R6: The status byte (read select 10) always has bits 6, 4, 3, 2, 1 and 0 set to 1. Bit 7 is the accepted flag and bit 5 is the partial flag.
- R7: Opcode 2 (write begin) clears the partial flag. Opcode 4 (write end) sets it if fewer than 8 bytes were stored, and clears it otherwise.
- R8: Write begin clears the accepted flag. A successful commit sets it.
- R9: Opcode 5 (commit), with no write open and the partial flag clear, raises `commit_o` for exactly the cycle after the command edge. During that cycle `commit_addr` carries the target address and `commit_data` carries offset k in bits 8k+7..8k.
- R10: A commit request while a write is open or while the partial flag is set produces no `commit_o` pulse and leaves the accepted flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 0 addr low, 1 addr high, 2 begin, 3 data byte, 4 end, 5 commit |
| cmd_data | input | 8 | Byte operand |
| rd_sel | input | 4 | Read select: 0..7 buffer, 8 addr low, 9 addr high, 10 status |
| rd_data | output | 8 | Selected byte, combinational |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_addr | output | 16 | Aligned target address |
| commit_data | output | 64 | Buffered block, offset 0 in the low byte |

## Verification
A wrong fill counter shows up on the very next read of the buffer: bytes land at a shifted offset, or a ninth byte overwrites offset 0. A flag that is stuck or cleared at the wrong time shows up in the status byte one cycle after the begin, end or commit command. It also shows as a commit strobe that appears when it should be refused, or that fails to appear, in the cycle right after the request. Address masking faults appear in the first readback after a low-byte load and again on `commit_addr`.

// File: rtl/spad_pkg.sv
package spad_pkg;
   typedef enum logic [2:0] {
      OP_ADDR_LO = 3'd0,
      OP_ADDR_HI = 3'd1,
      OP_WR_BEGIN = 3'd2,
      OP_WR_BYTE = 3'd3,
      OP_WR_END = 3'd4,
      OP_COMMIT = 3'd5
   } spad_op_e;

   localparam int ES_AA_BIT = 7;
   localparam int ES_PF_BIT = 5;
   localparam logic [7:0] ES_FIXED_ONES = 8'h5F;
endpackage

// File: rtl/spad_addr_reg.sv
module spad_addr_reg #(
   parameter int BYTE_W = 8,
   parameter int ALIGN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo_i,
   input  logic              ld_hi_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic [BYTE_W-1:0] ta_lo_o,
   output logic [BYTE_W-1:0] ta_hi_o
);
   localparam logic [BYTE_W-1:0] LO_MASK = ~((BYTE_W)'((1 << ALIGN) - 1));

   generate
      if (ALIGN >= BYTE_W) begin : g_bad_align
         $error("alignment must leave address bits in the low byte");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ta_lo_o <= '0;
         ta_hi_o <= '0;
      end else begin
         if (ld_lo_i) ta_lo_o <= data_i & LO_MASK;
         if (ld_hi_i) ta_hi_o <= data_i;
      end
   end

   // R2
   lo_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo_i |=> (ta_lo_o[ALIGN-1:0] == '0) &&
                  (ta_lo_o[BYTE_W-1:ALIGN] == $past(data_i[BYTE_W-1:ALIGN])));
   // R3
   hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_hi_i |=> ta_hi_o == $past(data_i));
endmodule

// File: rtl/spad_buffer.sv
module spad_buffer #(
   parameter int BYTE_W = 8,
   parameter int BLK_BYTES = 8,
   localparam int CNT_W = $clog2(BLK_BYTES + 1),
   localparam int IDX_W = $clog2(BLK_BYTES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        begin_i,
   input  logic                        wr_i,
   input  logic [BYTE_W-1:0]           data_i,
   input  logic [IDX_W-1:0]            rd_idx_i,
   output logic [BYTE_W-1:0]           rd_byte_o,
   output logic                        full_o,
   output logic [BLK_BYTES*BYTE_W-1:0] flat_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [BYTE_W-1:0] mem_q [BLK_BYTES];

   assign full_o = (cnt_q == CNT_W'(BLK_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (begin_i) cnt_q <= '0;
      else if (wr_i && !full_o) cnt_q <= cnt_q + 1'b1;
   end

   generate
      for (genvar i = 0; i < BLK_BYTES; i++) begin : g_byte
         always_ff @(posedge clk) begin
            if (!rst_n) mem_q[i] <= '0;
            else if (wr_i && !begin_i && cnt_q == CNT_W'(i)) mem_q[i] <= data_i;
         end
         assign flat_o[i*BYTE_W +: BYTE_W] = mem_q[i];
      end
   endgenerate

   assign rd_byte_o = mem_q[rd_idx_i];

   // R5
   overflow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && full_o && !begin_i) |=> $stable(flat_o));
   // R4
   fill_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !full_o && !begin_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/spad_status.sv
module spad_status (
   input  logic clk,
   input  logic rst_n,
   input  logic begin_i,
   input  logic end_i,
   input  logic commit_req_i,
   input  logic full_i,
   output logic open_o,
   output logic pf_o,
   output logic aa_o,
   output logic commit_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o   <= 1'b0;
         pf_o     <= 1'b1;
         aa_o     <= 1'b0;
         commit_o <= 1'b0;
      end else begin
         commit_o <= 1'b0;
         if (begin_i) begin
            open_o <= 1'b1;
            pf_o   <= 1'b0;
            aa_o   <= 1'b0;
         end else if (end_i && open_o) begin
            open_o <= 1'b0;
            pf_o   <= !full_i;
         end else if (commit_req_i && !open_o && !pf_o) begin
            commit_o <= 1'b1;
            aa_o     <= 1'b1;
         end
      end
   end

   // R7
   partial_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_i && open_o && !full_i) |=> pf_o);
   // R8
   aa_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      begin_i |=> !aa_o && !pf_o);
   // R8
   aa_with_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> aa_o);
   // R10
   commit_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req_i && (pf_o || open_o)) |=> !commit_o && (aa_o == $past(aa_o)));
   // R9
   commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o || $past(commit_req_i));
endmodule

// File: rtl/spad_stage.sv
module spad_stage #(
   parameter int BYTE_W = 8,
   parameter int BLK_BYTES = 8,
   localparam int ALIGN = $clog2(BLK_BYTES),
   localparam int RSEL_W = $clog2(BLK_BYTES + 3),
   localparam int ADDR_W = 2 * BYTE_W,
   localparam int DATA_W = BLK_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [BYTE_W-1:0] cmd_data,
   input  logic [RSEL_W-1:0] rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   output logic              commit_o,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   import spad_pkg::*;

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("status byte layout needs 8-bit bytes");
      end
      if (BLK_BYTES < 2 || BLK_BYTES > 8 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
         $error("block size must be a power of two from 2 to 8");
      end
   endgenerate

   spad_op_e op;
   logic do_lo, do_hi, do_begin, do_byte, do_end, do_commit;
   logic open_q, pf_q, aa_q, full;
   logic [BYTE_W-1:0] ta_lo, ta_hi, buf_byte, es_byte;

   assign op        = spad_op_e'(cmd_op);
   assign do_lo     = cmd_valid && op == OP_ADDR_LO;
   assign do_hi     = cmd_valid && op == OP_ADDR_HI;
   assign do_begin  = cmd_valid && op == OP_WR_BEGIN;
   assign do_byte   = cmd_valid && op == OP_WR_BYTE;
   assign do_end    = cmd_valid && op == OP_WR_END;
   assign do_commit = cmd_valid && op == OP_COMMIT;

   spad_addr_reg #(.BYTE_W(BYTE_W), .ALIGN(ALIGN)) u_addr (
      .clk(clk), .rst_n(rst_n), .ld_lo_i(do_lo), .ld_hi_i(do_hi),
      .data_i(cmd_data), .ta_lo_o(ta_lo), .ta_hi_o(ta_hi));

   spad_buffer #(.BYTE_W(BYTE_W), .BLK_BYTES(BLK_BYTES)) u_buf (
      .clk(clk), .rst_n(rst_n), .begin_i(do_begin), .wr_i(do_byte && open_q),
      .data_i(cmd_data), .rd_idx_i(rd_sel[ALIGN-1:0]), .rd_byte_o(buf_byte),
      .full_o(full), .flat_o(commit_data));

   spad_status u_stat (
      .clk(clk), .rst_n(rst_n), .begin_i(do_begin), .end_i(do_end),
      .commit_req_i(do_commit), .full_i(full), .open_o(open_q),
      .pf_o(pf_q), .aa_o(aa_q), .commit_o(commit_o));

   always_comb begin
      es_byte = ES_FIXED_ONES;
      es_byte[ES_AA_BIT] = aa_q;
      es_byte[ES_PF_BIT] = pf_q;
   end

   always_comb begin
      if (rd_sel < RSEL_W'(BLK_BYTES))          rd_data = buf_byte;
      else if (rd_sel == RSEL_W'(BLK_BYTES))     rd_data = ta_lo;
      else if (rd_sel == RSEL_W'(BLK_BYTES + 1)) rd_data = ta_hi;
      else if (rd_sel == RSEL_W'(BLK_BYTES + 2)) rd_data = es_byte;
      else                                       rd_data = '0;
   end

   assign commit_addr = {ta_hi, ta_lo};

   // R9
   commit_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> commit_addr[ALIGN-1:0] == '0);
   // R6
   es_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == RSEL_W'(BLK_BYTES + 2)) |-> (rd_data & ES_FIXED_ONES) == ES_FIXED_ONES);
endmodule

// File: tb/tb_spad_stage.sv
`timescale 1ns/100ps
module tb_spad_stage;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_data = 8'd0;
   logic [3:0] rd_sel = 4'd0;
   logic [7:0] rd_data;
   logic commit_o;
   logic [15:0] commit_addr;
   logic [63:0] commit_data;
   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   spad_stage dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .rd_sel(rd_sel), .rd_data(rd_data), .commit_o(commit_o),
      .commit_addr(commit_addr), .commit_data(commit_data));

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic op(logic [2:0] o, logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = o; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic rd(logic [3:0] s, output logic [7:0] v);
      rd_sel = s;
      #0.5;
      v = rd_data;
   endtask

   function automatic logic [7:0] es(bit aa, bit pf);
      return (aa ? 8'h80 : 8'h00) | (pf ? 8'h20 : 8'h00) | 8'h5F;
   endfunction

   task automatic t_reset();
      logic [7:0] v;
      rd(4'd8, v); check("R1 ta_lo", v, 8'h00);
      rd(4'd9, v); check("R1 ta_hi", v, 8'h00);
      rd(4'd10, v); check("R1 status", v, es(0, 1));
      check("R1 commit", commit_o, 1'b0);
   endtask

   task automatic t_addr();
      logic [7:0] v;
      op(3'd0, 8'hFF); rd(4'd8, v); check("R2 low masked", v, 8'hF8);
      op(3'd0, 8'h3D); rd(4'd8, v); check("R2 low masked", v, 8'h38);
      op(3'd1, 8'hA5); rd(4'd9, v); check("R3 high", v, 8'hA5);
   endtask

   task automatic t_full_write();
      logic [7:0] v;
      op(3'd2, 8'h00);
      rd(4'd10, v); check("R7 begin clears pf", v, es(0, 0));
      for (int i = 0; i < 8; i++) op(3'd3, 8'h10 + 8'(i));
      op(3'd3, 8'hEE);
      for (int i = 0; i < 8; i++) begin
         rd(4'(i), v); check("R4 readback", v, 8'h10 + 8'(i));
      end
      rd(4'd0, v); check("R5 ninth byte ignored", v, 8'h10);
      op(3'd4, 8'h00);
      rd(4'd10, v); check("R7 full end", v, es(0, 0));
      check("R6 fixed ones", v & 8'h5F, 8'h5F);
   endtask

   task automatic t_commit_ok();
      logic [7:0] v;
      op(3'd5, 8'h00);
      check("R9 strobe", commit_o, 1'b1);
      check("R9 addr", commit_addr, 16'hA538);
      check("R9 data", commit_data, 64'h1716151413121110);
      rd(4'd10, v); check("R8 aa set", v, es(1, 0));
      @(negedge clk);
      check("R9 single cycle", commit_o, 1'b0);
   endtask

   task automatic t_partial();
      logic [7:0] v;
      op(3'd2, 8'h00);
      rd(4'd10, v); check("R8 begin clears aa", v, es(0, 0));
      op(3'd3, 8'hA0); op(3'd3, 8'hA1); op(3'd3, 8'hA2);
      op(3'd4, 8'h00);
      rd(4'd10, v); check("R7 partial end", v, es(0, 1));
      op(3'd3, 8'h99);
      rd(4'd3, v); check("R5 byte outside write", v, 8'h13);
      rd(4'd2, v); check("R4 partial data", v, 8'hA2);
      op(3'd5, 8'h00);
      check("R10 refused on pf", commit_o, 1'b0);
      rd(4'd10, v); check("R10 aa unchanged", v, es(0, 1));
   endtask

   task automatic t_open_commit();
      logic [7:0] v;
      op(3'd2, 8'h00);
      for (int i = 0; i < 8; i++) op(3'd3, 8'hC0 + 8'(i));
      op(3'd5, 8'h00);
      check("R10 refused while open", commit_o, 1'b0);
      rd(4'd10, v); check("R10 status while open", v, es(0, 0));
      op(3'd4, 8'h00);
      op(3'd5, 8'h00);
      check("R9 strobe after end", commit_o, 1'b1);
      check("R9 data second block", commit_data, 64'hC7C6C5C4C3C2C1C0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_full_write();
      t_commit_ok();
      t_partial();
      t_open_commit();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule